// File: doc/BRIEF.md
# Sticky Event Register Bank with Snapshot Clear

This block holds two 16-bit sticky event words: a status word and an error word. Hardware event lines set bits in them, and a set bit stays set until the host removes it. The host reaches the bank through a simple register access path that sits behind a serial slave. That path provides a chip select, a read request, a clear request and a small address. The serial shifter, the frame decoding and any clock crossing are outside this block.

A read copies the addressed word into a 16-bit holding register, which feeds the shifter. The same read takes a private snapshot of that word. A later, separate clear command removes only the bits held in the snapshot. Bits that an event sets between the read and the clear therefore survive. Six status bit positions are protected and never cleared. The error word has no protected bits.

Every host command is edge-qualified, so a request held high for many clocks acts only once. The data path has no back-pressure. The holding register keeps its value until the next read that takes effect. Status and error contents are also driven out as plain pins.

Top module: `evt_latch_bank`

## Requirements
- R1: A synchronous active-high reset zeroes both event words, both snapshots, the holding register and the request delay flops.
- R2: Each event input bit ORs into its word on every clock, and a set bit stays set until a clear removes it.
- R3: On the first clock where `sel` and `rd_req` are both high, address 0 loads the status word into `rd_data` and address 1 loads the error word into `rd_data`. The value loaded is the word as it stood before that clock's events. Addresses 2 and 3 leave `rd_data` unchanged.
- R4: A read or clear request that stays high acts only on its first clock. A further action needs the request (ANDed with `sel`) to go low and then high again.
- R5: A read also stores the word it returns as that word's snapshot. A later clear, qualified by `sel` and `clr_req` at the same address, removes exactly the snapshot bits. Bits set after the read remain set.
- R6: Status bits 15, 14, 13, 5, 4 and 0 (mask 16'hE031) are never removed by a clear. Every error bit can be cleared.
- R7: In a clock where a clear is applied, an asserted event bit still ends up set (set wins over clear).
- R8: A clear empties its snapshot, so a clear with no read since reset, or a second clear after one read, removes nothing.
- R9: When a read and a clear take effect on the same clock, the read is performed and the clear is dropped.
- R10: A read does not change the content of the word it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select qualifying host requests |
| rd_req | input | 1 | Read request level |
| clr_req | input | 1 | Clear request level |
| addr | input | 2 | Word select: 0 status, 1 error |
| status_evt | input | 16 | Status event lines, set bits when high |
| error_evt | input | 16 | Error event lines, set bits when high |
| rd_data | output | 16 | Holding register feeding the shifter |
| status_q | output | 16 | Current status word |
| error_q | output | 16 | Current error word |

## Verification
The hardest case to reach is an event that lands after a read and before its clear, combined with a clear that must leave that event in place. The stimulus reads a word, injects new event bits in the idle cycles that follow, and then issues the clear. A second arrangement does the same with the event asserted in the very clock of the clear. Held requests that span several vectors, together with a read and clear raised in the same clock, test the edge qualification and the priority between the two commands.

// File: rtl/evt_latch_pkg.sv
package evt_latch_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int NREG   = 2;
  localparam logic [DATA_W-1:0] STATUS_KEEP_DEF = 16'hE031;
  localparam logic [DATA_W-1:0] ERROR_KEEP_DEF  = 16'h0000;
endpackage

// File: rtl/evt_edge_qual.sv
module evt_edge_qual #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pulse
);
  logic [N-1:0] lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign pulse[i] = lvl[i] & ~lvl_d[i];

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      pulse[i] |=> !pulse[i]) else $error("pulse repeated"); // R4
  end
endmodule

// File: rtl/evt_sticky_cell.sv
module evt_sticky_cell #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    KEEP = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         rd_hit,
  input  logic         clr_hit,
  output logic [W-1:0] q
);
  logic [W-1:0] snap;
  logic [W-1:0] q_next;

  always_comb begin
    if (clr_hit) q_next = (q & (~snap | KEEP)) | evt;
    else         q_next = q | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      snap <= '0;
    end else begin
      q <= q_next;
      if (rd_hit)       snap <= q;
      else if (clr_hit) snap <= '0;
    end
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> ((q & $past(q)) == $past(q))) else $error("bit dropped"); // R2
  AST_KEEP_BITS: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> ((q & $past(q) & KEEP) == ($past(q) & KEEP))) else $error("kept bit lost"); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((q & $past(evt)) == $past(evt))) else $error("event lost"); // R7
  AST_SNAP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !rd_hit) |=> (snap == '0)) else $error("snapshot kept"); // R8
  AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !clr_hit) |=> (q == ($past(q) | $past(evt)))) else $error("read altered word"); // R10
endmodule

// File: rtl/evt_read_port.sv
module evt_read_port #(
  parameter int W      = 16,
  parameter int NREG   = 2,
  parameter int ADDR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_fire,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NREG-1:0][W-1:0] words,
  output logic [W-1:0]           rd_data
);
  logic addr_ok;
  assign addr_ok = (int'(addr) < NREG);

  always_ff @(posedge clk) begin
    if (rst)                     rd_data <= '0;
    else if (rd_fire && addr_ok) rd_data <= words[addr];
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rd_data)) else $error("holding reg moved"); // R3
endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank
  import evt_latch_pkg::*;
#(
  parameter int                DW          = DATA_W,
  parameter int                AW          = ADDR_W,
  parameter logic [DW-1:0]     STATUS_KEEP = STATUS_KEEP_DEF,
  parameter logic [DW-1:0]     ERROR_KEEP  = ERROR_KEEP_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          rd_req,
  input  logic          clr_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] status_evt,
  input  logic [DW-1:0] error_evt,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] error_q
);
  localparam int NW = NREG;

  logic [1:0]            lvl;
  logic [1:0]            pulse;
  logic                  rd_fire;
  logic                  clr_fire;
  logic [NW-1:0][DW-1:0] evt_arr;
  logic [NW-1:0][DW-1:0] word_arr;
  logic [NW-1:0]         rd_hit;
  logic [NW-1:0]         clr_hit;

  assign lvl      = {sel & clr_req, sel & rd_req};
  assign rd_fire  = pulse[0];
  assign clr_fire = pulse[1] & ~pulse[0];
  assign evt_arr  = {error_evt, status_evt};

  evt_edge_qual #(.N(2)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .pulse(pulse)
  );

  for (genvar i = 0; i < NW; i++) begin : g_word
    localparam logic [DW-1:0] KEEP_I = (i == 0) ? STATUS_KEEP : ERROR_KEEP;
    assign rd_hit[i]  = rd_fire  && (addr == AW'(i));
    assign clr_hit[i] = clr_fire && (addr == AW'(i));

    evt_sticky_cell #(.W(DW), .KEEP(KEEP_I)) u_cell (
      .clk(clk), .rst(rst), .evt(evt_arr[i]),
      .rd_hit(rd_hit[i]), .clr_hit(clr_hit[i]), .q(word_arr[i])
    );
  end

  evt_read_port #(.W(DW), .NREG(NW), .ADDR_W(AW)) u_rd (
    .clk(clk), .rst(rst), .rd_fire(rd_fire), .addr(addr),
    .words(word_arr), .rd_data(rd_data)
  );

  assign status_q = word_arr[0];
  assign error_q  = word_arr[1];

  AST_RD_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_fire, clr_fire})) else $error("read and clear together"); // R9
endmodule

// File: tb/tb_evt_latch_bank.sv
`timescale 1ns/1ps
module tb_evt_latch_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic        sel, rd_req, clr_req;
  logic [1:0]  addr;
  logic [15:0] status_evt, error_evt;
  logic [15:0] rd_data, status_q, error_q;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  evt_latch_bank dut (
    .clk(clk), .rst(rst), .sel(sel), .rd_req(rd_req), .clr_req(clr_req),
    .addr(addr), .status_evt(status_evt), .error_evt(error_evt),
    .rd_data(rd_data), .status_q(status_q), .error_q(error_q)
  );

  typedef struct packed {
    logic        s, r, c;
    logic [1:0]  a;
    logic [15:0] se, ee, xrd, xs, xe;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,2'd0,16'h0006,16'h0000,16'h0000,16'h0006,16'h0000,4'd2},  // R2
    '{1'b0,1'b0,1'b0,2'd0,16'h8010,16'h0000,16'h0000,16'h8016,16'h0000,4'd2},  // R2
    '{1'b1,1'b1,1'b0,2'd0,16'h0000,16'h0000,16'h8016,16'h8016,16'h0000,4'd3},  // R3
    '{1'b1,1'b1,1'b0,2'd0,16'h0100,16'h0000,16'h8016,16'h8116,16'h0000,4'd4},  // R4 held read
    '{1'b0,1'b0,1'b0,2'd0,16'h0000,16'h0000,16'h8016,16'h8116,16'h0000,4'd10}, // R10
    '{1'b1,1'b0,1'b1,2'd0,16'h0000,16'h0000,16'h8016,16'h8110,16'h0000,4'd5},  // R5 R6
    '{1'b1,1'b0,1'b1,2'd0,16'h0000,16'h0000,16'h8016,16'h8110,16'h0000,4'd4},  // R4 held clear
    '{1'b0,1'b0,1'b0,2'd0,16'h0000,16'h0000,16'h8016,16'h8110,16'h0000,4'd4},
    '{1'b1,1'b0,1'b1,2'd0,16'h0000,16'h0000,16'h8016,16'h8110,16'h0000,4'd8},  // R8
    '{1'b0,1'b0,1'b0,2'd0,16'h0000,16'h00F0,16'h8016,16'h8110,16'h00F0,4'd2},
    '{1'b1,1'b1,1'b0,2'd1,16'h0000,16'h0000,16'h00F0,16'h8110,16'h00F0,4'd3},  // R3
    '{1'b0,1'b0,1'b0,2'd0,16'h0000,16'h0F00,16'h00F0,16'h8110,16'h0FF0,4'd5},
    '{1'b1,1'b0,1'b1,2'd1,16'h0000,16'h0010,16'h00F0,16'h8110,16'h0F10,4'd7},  // R7
    '{1'b0,1'b0,1'b0,2'd0,16'h0000,16'h0000,16'h00F0,16'h8110,16'h0F10,4'd7},
    '{1'b1,1'b1,1'b0,2'd2,16'h0000,16'h0000,16'h00F0,16'h8110,16'h0F10,4'd3},  // R3 bad addr
    '{1'b0,1'b0,1'b0,2'd0,16'h0000,16'h0000,16'h00F0,16'h8110,16'h0F10,4'd3},
    '{1'b0,1'b1,1'b0,2'd0,16'h0000,16'h0000,16'h00F0,16'h8110,16'h0F10,4'd4},
    '{1'b1,1'b1,1'b0,2'd0,16'h0000,16'h0000,16'h8110,16'h8110,16'h0F10,4'd4},  // R4 sel edge
    '{1'b0,1'b0,1'b0,2'd0,16'h0000,16'h0000,16'h8110,16'h8110,16'h0F10,4'd10}
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic r, input logic c,
                      input logic [1:0] a, input logic [15:0] se,
                      input logic [15:0] ee);
    @(negedge clk);
    sel = s; rd_req = r; clr_req = c; addr = a;
    status_evt = se; error_evt = ee;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0);
  endtask

  task automatic chk3(input string req, input logic [15:0] xrd,
                      input logic [15:0] xs, input logic [15:0] xe);
    chk(req, "rd_data",  rd_data,  xrd);
    chk(req, "status_q", status_q, xs);
    chk(req, "error_q",  error_q,  xe);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sel = 0; rd_req = 0; clr_req = 0; addr = 0;
    status_evt = 0; error_evt = 0;
    repeat (3) @(posedge clk);
    #1;
    chk3("R1", 16'h0, 16'h0, 16'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      step(VECS[i].s, VECS[i].r, VECS[i].c, VECS[i].a, VECS[i].se, VECS[i].ee);
      tag = $sformatf("R%0d v%0d", VECS[i].req, i);
      chk3(tag, VECS[i].xrd, VECS[i].xs, VECS[i].xe);
    end

    // R9: read and clear together -> read only
    step(1'b1, 1'b1, 1'b1, 2'd0, 16'h0, 16'h0);
    chk3("R9", 16'h8110, 16'h8110, 16'h0F10);
    idle();
    step(1'b1, 1'b0, 1'b1, 2'd0, 16'h0, 16'h0);
    chk3("R5", 16'h8110, 16'h8010, 16'h0F10);
    idle();
    step(1'b1, 1'b1, 1'b0, 2'd0, 16'h0, 16'h0);
    chk3("R10", 16'h8010, 16'h8010, 16'h0F10);
    idle();

    // R6: all bits set, then clear both words
    step(1'b0, 1'b0, 1'b0, 2'd0, 16'hFFFF, 16'hFFFF);
    chk3("R2", 16'h8010, 16'hFFFF, 16'hFFFF);
    step(1'b1, 1'b1, 1'b0, 2'd0, 16'h0, 16'h0);
    chk("R3", "rd_data", rd_data, 16'hFFFF);
    idle();
    step(1'b1, 1'b0, 1'b1, 2'd0, 16'h0, 16'h0);
    chk("R6", "status_q", status_q, 16'hE031);
    idle();
    step(1'b1, 1'b1, 1'b0, 2'd1, 16'h0, 16'h0);
    chk("R3", "rd_data", rd_data, 16'hFFFF);
    idle();
    step(1'b1, 1'b0, 1'b1, 2'd1, 16'h0, 16'h0);
    chk3("R6", 16'hFFFF, 16'hE031, 16'h0000);

    // R1: mid-run reset
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk3("R1", 16'h0, 16'h0, 16'h0);
    @(negedge clk); rst = 1'b0; sel = 0; clr_req = 0; rd_req = 0;

    // R8: clear with no read since reset
    step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0002, 16'h0004);
    idle();
    step(1'b1, 1'b0, 1'b1, 2'd0, 16'h0, 16'h0);
    chk("R8", "status_q", status_q, 16'h0002);
    idle();
    step(1'b1, 1'b0, 1'b1, 2'd1, 16'h0, 16'h0);
    chk("R8", "error_q", error_q, 16'h0004);
    chk("R1", "rd_data", rd_data, 16'h0000);
    idle();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule